// File: doc/BRIEF.md
# Adjustable Timebase Timer

This peripheral holds two 32-bit timers behind a simple synchronous register port made of a write strobe, a byte address, write data and combinational read data. The first timer is a reload counter. It counts up from zero, returns to zero after reaching a programmed limit, and feeds four compare channels. Each channel emits a one-cycle pulse when the counter arrives at that channel's value.

The second timer is a synchronisation time base. It advances by one per cycle while enabled. Software can step it forward or back by an operand, load it with the operand, or clear it, using command bits that act once and never stay set. A rising edge on an external trigger copies the synchronisation time into a save register. Each timer has its own enable for freezing while the CPU debug-mode input is high.

Top module: `timebase_timer`

## Requirements
- R1: After reset, every readable register reads zero and all compare pulses are low.
- R2: The register locations are as follows:
  - Control is at byte offset 0x00, and only bits 0, 1, 2, 4 and 5 are stored.
  - The reload limit is at 0x04 and the operand at 0x08.
  - Compare channel i is at 0x20+4·i.
  - All of these read back what was written, and other control bits read zero.
  - Writes to the read-only words at 0x0C, 0x10 and 0x14 change nothing.
- R3: While control bit 0 is set, the counter (read at 0x0C) rises by one per cycle. In the cycle after it equals the reload limit, it is zero.
- R4: While control bit 1 is set, the counter is held at zero, even if bit 0 is set.
- R5: With the debug input high, the counter freezes if control bit 2 is set, and the synchronisation time freezes if control bit 5 is set. Each enable affects only its own timer.
- R6: Output cmp_pulse[i] is high for exactly the cycles in which the counter has just advanced to compare value i. Holding the counter in reset produces no pulse.
- R7: While control bit 4 is set and no command is written, the synchronisation time (read at 0x14) rises by one per cycle, modulo 2^32.
- R8: A control write with bit 28 set clears the synchronisation time. Bit 29 loads the operand, bit 31 adds the operand and bit 30 subtracts it, all modulo 2^32.
  - The command takes effect in the cycle after the write, regardless of enable or debug state.
  - When several command bits are written together, the priority is clear, then load, then add, then subtract.
  - Command bits read back as zero.
- R9: A rising edge of trig_in, sampled at a clock edge, stores the synchronisation time held before that edge into the save register at 0x10. A trigger held high captures only once.
- R10: Reads of 0x18, 0x1C and 0x30 to 0x3C return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_halt | input | 1 | CPU debug-mode indication |
| trig_in | input | 1 | Capture trigger, rising-edge sensitive |
| cmp_pulse | output | 4 | Compare pulses, one per channel |

## Verification
On every cycle, the assertions check several step rules:
- the counter wraps after the limit;
- the counter holds at zero under its reset bit and stays stable when it does not advance;
- each pulse agrees with the counter and the previous compare value;
- a clear command yields zero;
- the synchronisation time is stable when idle;
- a trigger edge captures the prior time.

Only the bench scenarios can show the full command priority and the arithmetic with operand wrap. The same holds for register readback, the ignored writes to read-only and reserved words, and the single capture for a held trigger.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int unsigned TW = 32;
  localparam int unsigned CMP_BASE = 8;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_RELOAD = 1;
  localparam int unsigned IDX_OPND = 2;
  localparam int unsigned IDX_COUNT = 3;
  localparam int unsigned IDX_SAVE = 4;
  localparam int unsigned IDX_SYNC = 5;

  typedef struct packed {
    logic clr;
    logic load;
    logic add;
    logic sub;
  } sync_cmd_t;

  typedef struct packed {
    logic sync_dbg;
    logic sync_en;
    logic cnt_dbg;
    logic cnt_clr;
    logic cnt_en;
  } ctrl_t;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] cur,
                                             input logic [TW-1:0] lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [TW-1:0] sync_step(input logic [TW-1:0] cur,
                                              input logic [TW-1:0] opnd,
                                              input sync_cmd_t cmd,
                                              input logic run);
    if (cmd.clr) return '0;
    if (cmd.load) return opnd;
    if (cmd.add) return cur + opnd;
    if (cmd.sub) return cur - opnd;
    if (run) return cur + 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/tbt_regs.sv
module tbt_regs
  import tbt_pkg::*;
#(
  parameter int unsigned NCMP = 4,
  parameter int unsigned AW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [AW-1:0]            addr,
  input  logic [TW-1:0]            wdata,
  input  logic [TW-1:0]            count,
  input  logic [TW-1:0]            save,
  input  logic [TW-1:0]            sync_time,
  output ctrl_t                    ctrl,
  output logic [TW-1:0]            reload,
  output logic [TW-1:0]            opnd,
  output logic [NCMP-1:0][TW-1:0]  cmp_val,
  output sync_cmd_t                cmd,
  output logic [TW-1:0]            rdata
);
  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic          unused_addr_bits;
  logic          wr_ctrl;

  assign idx = addr[AW-1:2];
  assign unused_addr_bits = ^addr[1:0];
  assign wr_ctrl = wr && (idx == IW'(IDX_CTRL));

  assign cmd.clr  = wr_ctrl && wdata[28];
  assign cmd.load = wr_ctrl && wdata[29];
  assign cmd.add  = wr_ctrl && wdata[31];
  assign cmd.sub  = wr_ctrl && wdata[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      opnd   <= '0;
    end else if (wr) begin
      if (idx == IW'(IDX_CTRL)) begin
        ctrl.cnt_en   <= wdata[0];
        ctrl.cnt_clr  <= wdata[1];
        ctrl.cnt_dbg  <= wdata[2];
        ctrl.sync_en  <= wdata[4];
        ctrl.sync_dbg <= wdata[5];
      end
      if (idx == IW'(IDX_RELOAD)) reload <= wdata;
      if (idx == IW'(IDX_OPND)) opnd <= wdata;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_val[i] <= '0;
      else if (wr && idx == IW'(CMP_BASE + i)) cmp_val[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx)
      IW'(IDX_CTRL): begin
        rdata[0] = ctrl.cnt_en;
        rdata[1] = ctrl.cnt_clr;
        rdata[2] = ctrl.cnt_dbg;
        rdata[4] = ctrl.sync_en;
        rdata[5] = ctrl.sync_dbg;
      end
      IW'(IDX_RELOAD): rdata = reload;
      IW'(IDX_OPND):   rdata = opnd;
      IW'(IDX_COUNT):  rdata = count;
      IW'(IDX_SAVE):   rdata = save;
      IW'(IDX_SYNC):   rdata = sync_time;
      default: begin
        for (int j = 0; j < NCMP; j++)
          if (idx == IW'(CMP_BASE + j)) rdata = cmp_val[j];
      end
    endcase
  end
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter
  import tbt_pkg::*;
#(
  parameter int unsigned NCMP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     clr,
  input  logic                     dbg_en,
  input  logic                     dbg_halt,
  input  logic [TW-1:0]            reload,
  input  logic [NCMP-1:0][TW-1:0]  cmp_val,
  output logic [TW-1:0]            count,
  output logic [NCMP-1:0]          pulse
);
  logic          cnt_adv;
  logic [TW-1:0] cnt_nxt;

  assign cnt_adv = en && !clr && !(dbg_en && dbg_halt);
  assign cnt_nxt = wrap_inc(count, reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (clr) count <= '0;
    else if (cnt_adv) count <= cnt_nxt;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else pulse[i] <= cnt_adv && (cnt_nxt == cmp_val[i]);
    end

    // R6
    cmp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[i] |-> (count == $past(cmp_val[i])));
  end

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_adv && count == reload) |=> (count == '0));

  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R5
  cnt_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_adv && !clr) |=> $stable(count));
endmodule

// File: rtl/tbt_sync.sv
module tbt_sync
  import tbt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           dbg_en,
  input  logic           dbg_halt,
  input  sync_cmd_t      cmd,
  input  logic [TW-1:0]  opnd,
  input  logic           trig_in,
  output logic [TW-1:0]  sync_time,
  output logic [TW-1:0]  save
);
  logic sync_run;
  logic cmd_any;
  logic trig_q;
  logic trig_rise;

  assign sync_run  = en && !(dbg_en && dbg_halt);
  assign cmd_any   = cmd.clr || cmd.load || cmd.add || cmd.sub;
  assign trig_rise = trig_in && !trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_time <= '0;
    else sync_time <= sync_step(sync_time, opnd, cmd, sync_run);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      save   <= '0;
    end else begin
      trig_q <= trig_in;
      if (trig_rise) save <= sync_time;
    end
  end

  // R8
  sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> (sync_time == '0));

  // R7
  sync_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_any && !sync_run) |=> $stable(sync_time));

  // R9
  trig_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> (save == $past(sync_time)));

  // R9
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_rise |=> $stable(save));
endmodule

// File: rtl/timebase_timer.sv
module timebase_timer
  import tbt_pkg::*;
#(
  parameter int unsigned NCMP = 4,
  localparam int unsigned AW = $clog2((CMP_BASE + NCMP) * 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [TW-1:0]    bus_wdata,
  output logic [TW-1:0]    bus_rdata,
  input  logic             dbg_halt,
  input  logic             trig_in,
  output logic [NCMP-1:0]  cmp_pulse
);
  ctrl_t                    ctrl;
  sync_cmd_t                cmd;
  logic [TW-1:0]            reload;
  logic [TW-1:0]            opnd;
  logic [NCMP-1:0][TW-1:0]  cmp_val;
  logic [TW-1:0]            count;
  logic [TW-1:0]            save;
  logic [TW-1:0]            sync_time;

  tbt_regs #(.NCMP(NCMP), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .count(count), .save(save), .sync_time(sync_time), .ctrl(ctrl),
    .reload(reload), .opnd(opnd), .cmp_val(cmp_val), .cmd(cmd), .rdata(bus_rdata)
  );

  tbt_counter #(.NCMP(NCMP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.cnt_en), .clr(ctrl.cnt_clr),
    .dbg_en(ctrl.cnt_dbg), .dbg_halt(dbg_halt), .reload(reload),
    .cmp_val(cmp_val), .count(count), .pulse(cmp_pulse)
  );

  tbt_sync u_sync (
    .clk(clk), .rst_n(rst_n), .en(ctrl.sync_en), .dbg_en(ctrl.sync_dbg),
    .dbg_halt(dbg_halt), .cmd(cmd), .opnd(opnd), .trig_in(trig_in),
    .sync_time(sync_time), .save(save)
  );
endmodule

// File: tb/timebase_timer_test.sv
`timescale 1ns/1ps
module timebase_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        trig_in = 1'b0;
  logic [3:0]  cmp_pulse;

  int checks = 0;
  int errors = 0;
  string tag = "";

  timebase_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .trig_in(trig_in), .cmp_pulse(cmp_pulse)
  );

  always #5 clk = ~clk;

  // reference model state
  logic [5:0]  m_ctrl;
  logic [31:0] m_rld, m_nv, m_cnt, m_sync, m_save;
  logic [31:0] m_cmp [4];
  logic [3:0]  m_pulse;
  logic        m_trq;

  always @(posedge clk) begin
    logic [31:0] n_cnt, n_sync;
    logic        adv, srun;
    if (!rst_n) begin
      m_ctrl = '0; m_rld = '0; m_nv = '0; m_cnt = '0; m_sync = '0;
      m_save = '0; m_pulse = '0; m_trq = 1'b0;
      for (int i = 0; i < 4; i++) m_cmp[i] = '0;
    end else begin
      adv = m_ctrl[0] && !m_ctrl[1] && !(m_ctrl[2] && dbg_halt);
      n_cnt = m_cnt;
      if (m_ctrl[1]) n_cnt = 0;
      else if (adv) n_cnt = (m_cnt >= m_rld && m_cnt == m_rld) ? 32'd0 : m_cnt + 32'd1;
      for (int i = 0; i < 4; i++) m_pulse[i] = adv && (n_cnt == m_cmp[i]);
      srun = m_ctrl[4] && !(m_ctrl[5] && dbg_halt);
      n_sync = srun ? m_sync + 32'd1 : m_sync;
      if (bus_wr && bus_addr[5:2] == 4'd0) begin
        if (bus_wdata[30]) n_sync = m_sync - m_nv;
        if (bus_wdata[31]) n_sync = m_sync + m_nv;
        if (bus_wdata[29]) n_sync = m_nv;
        if (bus_wdata[28]) n_sync = 32'd0;
      end
      if (trig_in && !m_trq) m_save = m_sync;
      m_trq = trig_in;
      m_cnt = n_cnt;
      m_sync = n_sync;
      if (bus_wr) begin
        case (bus_addr[5:2])
          4'd0: m_ctrl = {bus_wdata[5:4], 1'b0, bus_wdata[2:0]};
          4'd1: m_rld = bus_wdata;
          4'd2: m_nv = bus_wdata;
          4'd8, 4'd9, 4'd10, 4'd11: m_cmp[bus_addr[3:2]] = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    case (a[5:2])
      4'd0: return {26'd0, m_ctrl};
      4'd1: return m_rld;
      4'd2: return m_nv;
      4'd3: return m_cnt;
      4'd4: return m_save;
      4'd5: return m_sync;
      4'd8, 4'd9, 4'd10, 4'd11: return m_cmp[a[3:2]];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [5:0] a);
    case (a[5:2])
      4'd3: return "R3";
      4'd4: return "R9";
      4'd5: return "R7";
      4'd0, 4'd1, 4'd2, 4'd8, 4'd9, 4'd10, 4'd11: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // one cycle: check outputs at the falling edge, then drive next inputs
  task automatic tick(input logic wr, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    chk((tag == "") ? addr_tag(bus_addr) : tag, bus_rdata, exp_read(bus_addr));
    chk("R6", {28'd0, cmp_pulse}, {28'd0, m_pulse});
    bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic wr_rd(input logic [5:0] a, input logic [31:0] d);
    tick(1'b1, a, d);
    tick(1'b0, a, 32'd0);
  endtask

  task automatic idle(input logic [5:0] a, input int n);
    for (int i = 0; i < n; i++) tick(1'b0, a, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    for (int a = 0; a < 16; a++) tick(1'b0, 6'(a * 4), 32'd0);
    // R2 readback, command/unused bits read zero, RO writes ignored
    tag = "R2";
    wr_rd(6'h04, 32'hA5A5_0003);
    wr_rd(6'h08, 32'h1234_5678);
    wr_rd(6'h2C, 32'hDEAD_BEEF);
    wr_rd(6'h00, 32'h0FFF_FFC8);
    wr_rd(6'h0C, 32'hFFFF_FFFF);
    wr_rd(6'h10, 32'hFFFF_FFFF);
    wr_rd(6'h14, 32'hFFFF_FFFF);
    // R3 counting and wrap
    tag = "R3";
    wr_rd(6'h04, 32'd5);
    wr_rd(6'h20, 32'd2);
    wr_rd(6'h24, 32'd5);
    wr_rd(6'h28, 32'd0);
    wr_rd(6'h2C, 32'd7);
    wr_rd(6'h00, 32'h1);
    idle(6'h0C, 16);
    // R4 hold in reset
    tag = "R4";
    wr_rd(6'h00, 32'h3);
    idle(6'h0C, 5);
    // R5 debug freezing, per-timer
    tag = "R5";
    wr_rd(6'h00, 32'h35);
    dbg_halt = 1'b1;
    idle(6'h0C, 4);
    idle(6'h14, 4);
    wr_rd(6'h00, 32'h11);
    idle(6'h0C, 3);
    idle(6'h14, 3);
    dbg_halt = 1'b0;
    // R8 commands and priority
    tag = "R8";
    wr_rd(6'h08, 32'd100);
    wr_rd(6'h00, 32'hF000_0010);
    wr_rd(6'h00, 32'hE000_0000);
    tick(1'b0, 6'h14, 0);
    wr_rd(6'h00, 32'hC000_0000);
    tick(1'b0, 6'h14, 0);
    wr_rd(6'h00, 32'h4000_0000);
    tick(1'b0, 6'h14, 0);
    wr_rd(6'h00, 32'h4000_0000);
    tick(1'b0, 6'h14, 0);
    dbg_halt = 1'b1;
    wr_rd(6'h00, 32'h8000_0030);
    tick(1'b0, 6'h14, 0);
    dbg_halt = 1'b0;
    // R7 free increment
    tag = "R7";
    wr_rd(6'h00, 32'h10);
    idle(6'h14, 6);
    // R9 held trigger captures once
    tag = "R9";
    trig_in = 1'b1;
    idle(6'h10, 6);
    trig_in = 1'b0;
    idle(6'h10, 2);
    trig_in = 1'b1;
    idle(6'h10, 3);
    trig_in = 1'b0;
    // R10 reserved
    tag = "R10";
    wr_rd(6'h18, 32'hFFFF_FFFF);
    wr_rd(6'h1C, 32'hFFFF_FFFF);
    wr_rd(6'h30, 32'hFFFF_FFFF);
    wr_rd(6'h3C, 32'hFFFF_FFFF);
    // constrained random mix
    tag = "";
    for (int n = 0; n < 4000; n++) begin
      logic [5:0]  a;
      logic [31:0] d;
      logic        w;
      a = 6'($urandom_range(0, 15) * 4);
      w = ($urandom_range(0, 3) == 0);
      d = $urandom;
      if (a == 6'h00) begin
        d[27:6] = '0;
        if ($urandom_range(0, 7) != 0) d[1] = 1'b0;
        if ($urandom_range(0, 3) != 0) d[31:28] = '0;
      end else if (a == 6'h04 || a[5]) begin
        d = 32'($urandom_range(0, 30));
      end
      dbg_halt = ($urandom_range(0, 4) == 0);
      trig_in = ($urandom_range(0, 2) == 0);
      tick(w, a, d);
    end
    tick(1'b0, 6'h0C, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule